// File: doc/BRIEF.md
# Tiled Matrix-Vector Multiply-Accumulate Array

This block evaluates one fully connected neural-network layer as a series of tiles. A 16-row by 16-column grid of multiply-accumulate cells takes, on every accepted step, a vector of 16 signed fixed-point operands and a 16x16 block of signed fixed-point weights. Each row forms the dot product of its weight row with the operand vector. The cells of a row form a cascade: the first adder is seeded with the row's running partial sum, and every cell passes its sum to the adder of the next cell. One tile step therefore completes in a single clock.

A sequencer counts accepted tiles inside an output group and counts the groups that make up the layer. While a group is still open, the 16 row totals return to the accumulators for the next tile. On the group's last tile they are registered onto the output bus with a one-cycle valid strobe, and the accumulators start again from zero. The layer is zero-padded to whole tiles. With the defaults, one group is 49 input blocks and the layer has 7 groups. These values match a 784-input, 112-output layer. The operand and weight memories, the loading of tiles and the activation function all lie outside the block. A loader uses the block and group indices that the block reports to choose which tile to present next.

The sequencer has two states. In IDLE it waits for a start pulse and ignores tiles. In RUN it accepts tiles. The transitions are: IDLE to RUN on start (named LAUNCH); RUN to RUN on start (named RESTART, which discards the partial sums); RUN to IDLE when the last tile of the last group is accepted (named FINISH). In every other case the state holds.

Top module: `tiled_mac_array`

## Requirements
- R1: After reset, out_valid, done and busy are 0, blk_idx and grp_idx are 0, and out_sum is all zeros.
- R2: For each accepted tile, row r adds the sum over columns c of weight(r,c) times data(c) to its partial sum. data(c) is data_blk[c*16 +: 16]. weight(r,c) is wgt_blk[(r*16+c)*16 +: 16]. Both are signed two's complement with 12 fraction bits. Each product is the full 32-bit signed product with 24 fraction bits. The total of row r appears on out_sum[r*32 +: 32].
- R3: The partial sums carry across the BLOCKS accepted tiles of a group. out_sum and out_valid change at the clock edge that accepts the group's last tile. out_valid is high for exactly that one cycle and is 0 at every other time.
- R4: Accumulation is modulo 2^32: a row sum that overflows wraps around in two's complement and does not saturate.
- R5: A cycle in RUN with tile_valid low accepts nothing: the partial sums, blk_idx and grp_idx all hold.
- R6: While the block is idle (busy 0), tile_valid has no effect: out_valid stays 0, the indices stay 0, and nothing presented at that time enters a later result.
- R7: A start pulse clears all partial sums and both indices and sets busy on the next cycle. This applies in any state, including in the middle of a layer. A tile presented together with start is not accepted.
- R8: blk_idx counts accepted tiles from 0 to BLOCKS-1 and then wraps to 0. grp_idx increments at each wrap.
- R9: done is high for exactly the one cycle in which the last group's out_valid is high. busy falls in that same cycle.
- R10: The partial sums restart from zero after each group is released, so each group's result contains only that group's tiles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins or restarts a layer |
| tile_valid | input | 1 | A tile is presented this cycle |
| data_blk | input | 256 | 16 signed 16-bit operands |
| wgt_blk | input | 4096 | 16x16 signed 16-bit weights, row-major |
| busy | output | 1 | Sequencer is in RUN |
| blk_idx | output | 6 | Index of the next input block inside the group |
| grp_idx | output | 3 | Index of the current output group |
| out_valid | output | 1 | out_sum holds a released group result |
| out_sum | output | 512 | 16 signed 32-bit row totals |
| done | output | 1 | Last group of the layer released |

## Verification
Dense uniform-random tiles test the cascade arithmetic and the row and column bit placement in general. Mostly-zero tiles check that sparse inputs give the same exact sums and that no stale partial sum leaks between groups. Tiles built only from the two largest-magnitude operand values force the 32-bit sums to wrap, which separates a wrapping accumulator from a saturating or wider one. Random gaps in tile_valid, tiles offered while idle, and a restart in the middle of a layer show whether the sequencer accepts exactly the intended tiles.

// File: rtl/mac_tile_pkg.sv
package mac_tile_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/mac_cell.sv
module mac_cell #(
    parameter int DW = 16,
    parameter int AW = 32
) (
    input  logic signed [DW-1:0] w_i,
    input  logic signed [DW-1:0] d_i,
    input  logic signed [AW-1:0] sum_i,
    output logic signed [AW-1:0] sum_o
);
    logic signed [AW-1:0] w_ext;
    logic signed [AW-1:0] d_ext;
    logic signed [AW-1:0] prod;

    assign w_ext = {{(AW-DW){w_i[DW-1]}}, w_i};
    assign d_ext = {{(AW-DW){d_i[DW-1]}}, d_i};
    assign prod  = w_ext * d_ext;
    assign sum_o = sum_i + prod;

    initial begin
        assert_width_fits_R2: assert (AW >= 2*DW)
            else $error("accumulator narrower than a full product");
    end
endmodule

// File: rtl/mac_row.sv
module mac_row #(
    parameter int COLS = 16,
    parameter int DW   = 16,
    parameter int AW   = 32
) (
    input  logic [COLS*DW-1:0] w_row_i,
    input  logic [COLS*DW-1:0] d_vec_i,
    input  logic [AW-1:0]      seed_i,
    output logic [AW-1:0]      total_o
);
    logic [AW-1:0] link [0:COLS];

    assign link[0] = seed_i;

    for (genvar c = 0; c < COLS; c++) begin : g_cell
        logic [AW-1:0] cell_out;
        mac_cell #(.DW(DW), .AW(AW)) u_cell (
            .w_i   (w_row_i[c*DW +: DW]),
            .d_i   (d_vec_i[c*DW +: DW]),
            .sum_i (link[c]),
            .sum_o (cell_out)
        );
        assign link[c+1] = cell_out;
    end

    assign total_o = link[COLS];
endmodule

// File: rtl/tile_seq.sv
module tile_seq
    import mac_tile_pkg::*;
#(
    parameter int BLOCKS = 49,
    parameter int GROUPS = 7,
    localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          tile_valid_i,
    output logic          busy_o,
    output logic [BW-1:0] blk_idx_o,
    output logic [GW-1:0] grp_idx_o,
    output logic          accept_o,
    output logic          release_o,
    output logic          final_o
);
    localparam logic [BW-1:0] BLK_LAST = BW'(BLOCKS-1);
    localparam logic [GW-1:0] GRP_LAST = GW'(GROUPS-1);

    seq_state_t    state_q, state_d;
    logic [BW-1:0] blk_q;
    logic [GW-1:0] grp_q;
    logic          last_blk, last_grp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start_i) state_d = SEQ_RUN;
            SEQ_RUN: begin
                if (start_i)      state_d = SEQ_RUN;
                else if (final_o) state_d = SEQ_IDLE;
            end
        endcase
    end

    always_comb begin
        busy_o    = (state_q == SEQ_RUN);
        last_blk  = (blk_q == BLK_LAST);
        last_grp  = (grp_q == GRP_LAST);
        accept_o  = busy_o && tile_valid_i && !start_i;
        release_o = accept_o && last_blk;
        final_o   = release_o && last_grp;
        blk_idx_o = blk_q;
        grp_idx_o = grp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= '0;
            grp_q <= '0;
        end else if (start_i) begin
            blk_q <= '0;
            grp_q <= '0;
        end else if (accept_o) begin
            if (last_blk) begin
                blk_q <= '0;
                grp_q <= last_grp ? '0 : grp_q + 1'b1;
            end else begin
                blk_q <= blk_q + 1'b1;
            end
        end
    end

    assert_blk_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_q <= BLK_LAST)
        else $error("block index beyond last block");

    assert_blk_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (blk_q == '0))
        else $error("block index did not wrap after release");

    assert_hold_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tile_valid_i && !start_i) |=> ($stable(blk_q) && $stable(grp_q)))
        else $error("indices moved without an accepted tile");

    assert_start_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && blk_q == '0 && grp_q == '0))
        else $error("start did not reset the sequencer");
endmodule

// File: rtl/tiled_mac_array.sv
module tiled_mac_array #(
    parameter int ROWS   = 16,
    parameter int COLS   = 16,
    parameter int DW     = 16,
    parameter int AW     = 32,
    parameter int BLOCKS = 49,
    parameter int GROUPS = 7,
    localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    tile_valid,
    input  logic [COLS*DW-1:0]      data_blk,
    input  logic [ROWS*COLS*DW-1:0] wgt_blk,
    output logic                    busy,
    output logic [BW-1:0]           blk_idx,
    output logic [GW-1:0]           grp_idx,
    output logic                    out_valid,
    output logic [ROWS*AW-1:0]      out_sum,
    output logic                    done
);
    localparam int ROW_W = COLS*DW;

    logic               accept, release_grp, final_grp;
    logic [ROWS*AW-1:0] acc_q;
    logic [ROWS*AW-1:0] row_total;

    tile_seq #(.BLOCKS(BLOCKS), .GROUPS(GROUPS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .tile_valid_i (tile_valid),
        .busy_o       (busy),
        .blk_idx_o    (blk_idx),
        .grp_idx_o    (grp_idx),
        .accept_o     (accept),
        .release_o    (release_grp),
        .final_o      (final_grp)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        mac_row #(.COLS(COLS), .DW(DW), .AW(AW)) u_row (
            .w_row_i (wgt_blk[r*ROW_W +: ROW_W]),
            .d_vec_i (data_blk),
            .seed_i  (acc_q[r*AW +: AW]),
            .total_o (row_total[r*AW +: AW])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (start) begin
            acc_q <= '0;
        end else if (accept) begin
            acc_q <= release_grp ? '0 : row_total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= release_grp;
            done      <= final_grp;
            if (release_grp) out_sum <= row_total;
        end
    end

    assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (acc_q == '0))
        else $error("partial sums not zero while idle");

    assert_gap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tile_valid && !start) |=> $stable(acc_q))
        else $error("partial sums changed during a gap");

    assert_start_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (acc_q == '0 && !out_valid))
        else $error("start did not flush the partial sums");

    assert_done_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && !busy))
        else $error("done without a final release");

    assert_group_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (acc_q == '0))
        else $error("partial sums survived a release");

    if (BLOCKS > 1) begin : g_pulse_chk
        assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |=> !out_valid)
            else $error("out_valid longer than one cycle");
    end
endmodule

// File: tb/tiled_mac_array_bench.sv
module tiled_mac_array_bench;
    localparam int ROWS = 16, COLS = 16, DW = 16, AW = 32;
    localparam int BLOCKS = 49, GROUPS = 7, BW = 6, GW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tile_valid = 1'b0;
    logic [COLS*DW-1:0]      data_blk = '0;
    logic [ROWS*COLS*DW-1:0] wgt_blk = '0;
    logic                    busy, out_valid, done;
    logic [BW-1:0]           blk_idx;
    logic [GW-1:0]           grp_idx;
    logic [ROWS*AW-1:0]      out_sum;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;
    logic [AW-1:0] exp_acc [ROWS];

    always #5 clk = ~clk;

    tiled_mac_array u_tiled_mac_array (
        .clk(clk), .rst_n(rst_n), .start(start), .tile_valid(tile_valid),
        .data_blk(data_blk), .wgt_blk(wgt_blk), .busy(busy),
        .blk_idx(blk_idx), .grp_idx(grp_idx), .out_valid(out_valid),
        .out_sum(out_sum), .done(done)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic chk(bit ok, string req, string what, logic [ROWS*AW-1:0] act, logic [ROWS*AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] row_dot(int r);
        logic [AW-1:0] s = '0;
        for (int c = 0; c < COLS; c++) begin
            logic [DW-1:0] w = wgt_blk[(r*COLS+c)*DW +: DW];
            logic [DW-1:0] d = data_blk[c*DW +: DW];
            logic signed [AW-1:0] p = $signed({{(AW-DW){w[DW-1]}}, w}) * $signed({{(AW-DW){d[DW-1]}}, d});
            s = s + p;
        end
        return s;
    endfunction

    function automatic logic [DW-1:0] pick(int mode);
        case (mode)
            1:       return ($urandom % 2) ? 16'h8000 : 16'h7FFF;
            2:       return (($urandom % 4) == 0) ? DW'($urandom % 4096) - 16'd2048 : '0;
            default: return DW'($urandom);
        endcase
    endfunction

    task automatic fill_tile(int mode);
        for (int c = 0; c < COLS; c++) data_blk[c*DW +: DW] = pick(mode);
        for (int k = 0; k < ROWS*COLS; k++) wgt_blk[k*DW +: DW] = pick(mode);
    endtask

    function automatic logic [ROWS*AW-1:0] exp_flat();
        logic [ROWS*AW-1:0] v;
        for (int r = 0; r < ROWS; r++) v[r*AW +: AW] = exp_acc[r];
        return v;
    endfunction

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        tile_valid = 1'($urandom % 2);
        fill_tile(0);
        @(posedge clk); #1;
        chk(busy && blk_idx == 0 && grp_idx == 0 && !out_valid, "R7", "start state",
            {busy, blk_idx, grp_idx, out_valid}, {1'b1, 6'd0, 3'd0, 1'b0});
    endtask

    task automatic run_layer(int mode, int hole_pct, string tag);
        do_start();
        for (int g = 0; g < GROUPS; g++) begin
            for (int r = 0; r < ROWS; r++) exp_acc[r] = '0;
            for (int b = 0; b < BLOCKS; b++) begin
                while (int'($urandom % 100) < hole_pct) begin
                    @(negedge clk);
                    start = 1'b0; tile_valid = 1'b0; fill_tile(0);
                    @(posedge clk); #1;
                    chk(!out_valid, "R5", "gap produced output", {511'd0, out_valid}, '0);
                end
                @(negedge clk);
                chk(blk_idx == BW'(b) && grp_idx == GW'(g), "R8", "indices",
                    {blk_idx, grp_idx}, {BW'(b), GW'(g)});
                start = 1'b0; tile_valid = 1'b1;
                fill_tile(mode);
                for (int r = 0; r < ROWS; r++) exp_acc[r] = exp_acc[r] + row_dot(r);
                @(posedge clk); #1;
                if (b == BLOCKS-1) begin
                    chk(out_valid, "R3", "release strobe", {511'd0, out_valid}, {511'd0, 1'b1});
                    chk(out_sum == exp_flat(), tag, "group sums (R2 R10)", out_sum, exp_flat());
                    chk(done == (g == GROUPS-1) && busy == (g != GROUPS-1), "R9", "done/busy",
                        {done, busy}, {g == GROUPS-1, g != GROUPS-1});
                end else begin
                    chk(!out_valid && !done, "R3", "early strobe", {out_valid, done}, '0);
                end
            end
        end
        @(negedge clk);
        tile_valid = 1'b0;
        @(posedge clk); #1;
        chk(!out_valid && !done && !busy, "R9", "after layer", {out_valid, done, busy}, '0);
    endtask

    task automatic idle_poke();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            start = 1'b0; tile_valid = 1'b1; fill_tile(0);
            @(posedge clk); #1;
            chk(!out_valid && !busy && blk_idx == 0 && grp_idx == 0, "R6", "idle tile",
                {out_valid, busy, blk_idx, grp_idx}, '0);
        end
        @(negedge clk);
        tile_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        chk(!out_valid && !done && !busy && blk_idx == 0 && grp_idx == 0 && out_sum == '0,
            "R1", "reset state", {out_valid, done, busy, blk_idx, grp_idx}, '0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!out_valid && !busy && out_sum == '0, "R1", "after reset", out_sum, '0);

        idle_poke();                          // R6
        run_layer(0, 0,  "R2");               // dense random, back to back
        run_layer(2, 30, "R5");               // sparse tiles with gaps
        idle_poke();                          // R6 after a finished layer
        run_layer(1, 10, "R4");               // extreme operands, wrapping sums

        do_start();                           // R7: partial layer then restart
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            start = 1'b0; tile_valid = 1'b1; fill_tile(1);
        end
        run_layer(0, 20, "R7");

        report();
    end
endmodule